// File: doc/BRIEF.md
# UART Receive Error and Break Detector

This block takes a serial line, sampled once per bit time and qualified by a bit-rate enable, and turns it into characters of 5 to 8 data bits with optional even or odd parity. Along the way it flags characters whose stop bit is missing, recognises break conditions on the line, and measures how long each break lasts. It also keeps saturating counts of framing errors and of breaks.

The surrounding receive engine uses the block's buffer-close request to finish the buffer it is filling. A close carries either a framing flag or a break flag. The engine also uses the break-start and break-end pulses to raise its own events. A hunt pulse tells an address-recognition stage in multidrop operation to go back to searching.

Characters leave through a valid/ready port. A character is held, unchanged, until it is accepted. The serial line cannot be stalled, so a character that completes while the previous one is still waiting is discarded. The incoming bit stream has no handshake.

An option that applies only in synchronous mode lets the receiver resynchronise on a zero. When the stop bit reads zero, that zero is taken as the start bit of the next character. In this option, a break also needs two all-zero characters in a row before it is declared.

Top module: `uart_rx_guard`

## Requirements
- R1: After reset, `chr_valid`, every pulse output, `brk_len`, `fr_count` and `brk_count` are zero.
- R2: `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data is received least significant bit first after a zero start bit. Unused upper bits of `chr_data` are zero. `chr_valid` rises in the cycle after the stop bit's enable cycle and stays, with stable data, until `chr_ready` is high. A character that completes while one is still held is dropped.
- R3: `cfg_parity` 1 selects even parity and 2 selects odd parity; 0 and 3 mean no parity bit. The parity bit follows the data bits. `chr_perr` is set when the parity bit does not match.
- R4: A character whose stop bit is 0 and which is not treated as a break is still delivered, with `chr_fr`=1 and `chr_perr`=0. The block pulses `close_pulse` with `close_fr`=1 and increments `fr_count`.
- R5: When `cfg_multidrop` is 1, every framing error also pulses `hunt_pulse`. When `cfg_multidrop` is 0, `hunt_pulse` stays low.
- R6: An all-zero character is one whose data bits, parity bit (if any) and stop bit are all 0. Outside the resynchronise option, such a character declares a break: `brk_start` pulses, `brk_count` increments, no character is delivered and no framing error is raised.
- R7: When a break is declared and at least one good character has been delivered since the last close, the block pulses `close_pulse` with `close_br`=1. Otherwise no close is issued for the break.
- R8: Break length is counted in whole character times, starting from the start bit of the first break character, and saturates at all ones. The break ends on the first high bit. At that point `brk_len` is written and `brk_end` pulses.
- R9: With `cfg_sync`=1 and `cfg_rzs`=1, a zero stop bit is reported as a framing error, and that zero serves as the start bit of the next character.
- R10: With `cfg_sync`=1 and `cfg_rzs`=1, the first all-zero character is a framing error. A second all-zero character directly after it declares the break, and the break length starts at 2.
- R11: With `cfg_sync`=0, `cfg_rzs` has no effect.
- R12: `fr_count` and `brk_count` saturate at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per bit time |
| rx_bit | input | 1 | Sampled line level, read when `bit_en` is high |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_parity | input | 2 | 0/3 none, 1 even, 2 odd |
| cfg_sync | input | 1 | Synchronous mode |
| cfg_rzs | input | 1 | Resynchronise on zero (synchronous mode only) |
| cfg_multidrop | input | 1 | Automatic multidrop operation |
| chr_valid | output | 1 | Held character available |
| chr_ready | input | 1 | Consumer accepts the held character |
| chr_data | output | 8 | Received data bits |
| chr_fr | output | 1 | Character had a framing error |
| chr_perr | output | 1 | Character had a parity error |
| close_pulse | output | 1 | Buffer-close request |
| close_fr | output | 1 | Close caused by a framing error |
| close_br | output | 1 | Close caused by a break |
| hunt_pulse | output | 1 | Return multidrop receiver to hunt |
| brk_start | output | 1 | Break-start event pulse |
| brk_end | output | 1 | Break-end event pulse |
| brk_len | output | LEN_W | Last break length in character times |
| fr_count | output | CNT_W | Saturating framing-error count |
| brk_count | output | CNT_W | Saturating break count |

## Verification
The bench builds the block with `CNT_W`=3 and `LEN_W`=4. With those widths, both event counters can be pushed past seven events, and a break of about twenty character times can overflow the length register, all within a short run. The bit-rate enable fires every fourth clock, so each check catches the output pulses in the cycle that follows the relevant stop bit or high bit.

// File: rtl/uart_rxe_pkg.sv
package uart_rxe_pkg;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAR, ST_STOP} frm_st_e;

  typedef struct packed {
    logic [7:0] data;
    logic       fr;
    logic       perr;
  } rx_char_t;
endpackage

// File: rtl/uart_rxe_frame.sv
module uart_rxe_frame
  import uart_rxe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic [1:0] data_len,
  input  logic [1:0] par_mode,
  input  logic       resync,
  input  logic       hold,
  output logic       fin_ok,
  output logic       fin_fr,
  output logic       brk_go,
  output rx_char_t   fin_char
);
  frm_st_e    st_q;
  logic [2:0] idx_q;
  logic [7:0] dat_q;
  logic       par_bit_q;
  logic       prev_zero_q;

  logic       par_en;
  logic [2:0] last_idx;
  logic       fin;
  logic       zero_chr;
  logic       par_sum;
  logic       perr;

  assign par_en   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
  assign last_idx = 3'd4 + {1'b0, data_len};
  assign fin      = bit_en && !hold && (st_q == ST_STOP);

  // all-zero frame: data, parity and stop all low
  assign zero_chr = (dat_q == 8'd0) && !(par_en && par_bit_q) && !rx_bit;
  // with resync, a break needs the previous frame to be all-zero as well
  assign brk_go   = fin && zero_chr && (!resync || prev_zero_q);
  assign fin_fr   = fin && !rx_bit && !brk_go;
  assign fin_ok   = fin && rx_bit;

  assign par_sum  = (^dat_q) ^ par_bit_q;
  // parity is only judged when the stop bit is present
  assign perr     = par_en && rx_bit &&
                    ((par_mode == PAR_EVEN) ? par_sum : !par_sum);

  assign fin_char = '{data: dat_q, fr: !rx_bit, perr: perr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      dat_q       <= '0;
      par_bit_q   <= 1'b0;
      prev_zero_q <= 1'b0;
    end else if (bit_en && !hold) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!rx_bit) begin
            st_q      <= ST_DATA;
            idx_q     <= '0;
            dat_q     <= '0;
            par_bit_q <= 1'b0;
          end
        end
        ST_DATA: begin
          dat_q[idx_q] <= rx_bit;
          if (idx_q == last_idx) st_q <= par_en ? ST_PAR : ST_STOP;
          else                   idx_q <= idx_q + 3'd1;
        end
        ST_PAR: begin
          par_bit_q <= rx_bit;
          st_q      <= ST_STOP;
        end
        ST_STOP: begin
          prev_zero_q <= zero_chr && resync && !brk_go;
          if (!rx_bit && resync && !brk_go) begin
            // the missing stop bit doubles as the next start bit
            st_q      <= ST_DATA;
            idx_q     <= '0;
            dat_q     <= '0;
            par_bit_q <= 1'b0;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rxe_brkmeter.sv
module uart_rxe_brkmeter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             go,
  input  logic             two_chars,
  input  logic [3:0]       frame_bits,
  output logic             active,
  output logic             end_pulse,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [LEN_W-1:0] acc_q;
  logic [3:0]       bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      end_pulse <= 1'b0;
      len       <= '0;
      acc_q     <= '0;
      bcnt_q    <= '0;
    end else begin
      end_pulse <= 1'b0;
      if (go) begin
        active <= 1'b1;
        acc_q  <= two_chars ? LEN_W'(2) : LEN_W'(1);
        bcnt_q <= '0;
      end else if (active && bit_en) begin
        if (rx_bit) begin
          active    <= 1'b0;
          len       <= acc_q;
          end_pulse <= 1'b1;
        end else if (bcnt_q == frame_bits - 4'd1) begin
          bcnt_q <= '0;
          if (acc_q != LEN_MAX) acc_q <= acc_q + LEN_W'(1);
        end else begin
          bcnt_q <= bcnt_q + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rxe_satcnt.sv
module uart_rxe_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (inc && cnt != CNT_MAX)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/uart_rxe_hold.sv
module uart_rxe_hold
  import uart_rxe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  rx_char_t in_chr,
  output logic     valid,
  input  logic     ready,
  output rx_char_t out_chr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      out_chr <= '0;
    end else if (load && (!valid || ready)) begin
      valid   <= 1'b1;
      out_chr <= in_chr;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_guard.sv
module uart_rx_guard
  import uart_rxe_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_parity,
  input  logic             cfg_sync,
  input  logic             cfg_rzs,
  input  logic             cfg_multidrop,
  output logic             chr_valid,
  input  logic             chr_ready,
  output logic [7:0]       chr_data,
  output logic             chr_fr,
  output logic             chr_perr,
  output logic             close_pulse,
  output logic             close_fr,
  output logic             close_br,
  output logic             hunt_pulse,
  output logic             brk_start,
  output logic             brk_end,
  output logic [LEN_W-1:0] brk_len,
  output logic [CNT_W-1:0] fr_count,
  output logic [CNT_W-1:0] brk_count
);
  localparam int NUM_CNT = 2;

  logic       resync;
  logic       par_en;
  logic [3:0] frame_bits;
  logic       fin_ok, fin_fr, brk_go;
  rx_char_t   fin_char, held_chr;
  logic       brk_active;
  logic       pending_q;
  logic       br_close;

  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  assign resync     = cfg_sync && cfg_rzs;
  assign par_en     = (cfg_parity == PAR_EVEN) || (cfg_parity == PAR_ODD);
  assign frame_bits = 4'd7 + {2'b00, cfg_len} + {3'b000, par_en};
  assign br_close   = brk_go && pending_q;

  uart_rxe_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .data_len (cfg_len),
    .par_mode (cfg_parity),
    .resync   (resync),
    .hold     (brk_active),
    .fin_ok   (fin_ok),
    .fin_fr   (fin_fr),
    .brk_go   (brk_go),
    .fin_char (fin_char)
  );

  uart_rxe_brkmeter #(.LEN_W(LEN_W)) u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .rx_bit     (rx_bit),
    .go         (brk_go),
    .two_chars  (resync),
    .frame_bits (frame_bits),
    .active     (brk_active),
    .end_pulse  (brk_end),
    .len        (brk_len)
  );

  uart_rxe_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fin_ok || fin_fr),
    .in_chr  (fin_char),
    .valid   (chr_valid),
    .ready   (chr_ready),
    .out_chr (held_chr)
  );

  assign chr_data = held_chr.data;
  assign chr_fr   = held_chr.fr;
  assign chr_perr = held_chr.perr;

  assign cnt_inc[0] = fin_fr;
  assign cnt_inc[1] = brk_go;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    uart_rxe_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .cnt   (cnt_val[g])
    );
  end

  assign fr_count  = cnt_val[0];
  assign brk_count = cnt_val[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      close_pulse <= 1'b0;
      close_fr    <= 1'b0;
      close_br    <= 1'b0;
      hunt_pulse  <= 1'b0;
      brk_start   <= 1'b0;
      pending_q   <= 1'b0;
    end else begin
      close_pulse <= fin_fr || br_close;
      close_fr    <= fin_fr;
      close_br    <= br_close;
      hunt_pulse  <= fin_fr && cfg_multidrop;
      brk_start   <= brk_go;
      if (fin_fr || br_close) pending_q <= 1'b0;
      else if (fin_ok)        pending_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_guard_chk.sv
module uart_rx_guard_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chr_valid,
  input logic             chr_ready,
  input logic [7:0]       chr_data,
  input logic             chr_fr,
  input logic             close_pulse,
  input logic             close_fr,
  input logic             close_br,
  input logic             hunt_pulse,
  input logic             brk_start,
  input logic             brk_end,
  input logic [CNT_W-1:0] fr_count,
  input logic [CNT_W-1:0] brk_count
);
  // R2: a held character stays put until taken
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && !chr_ready |=> chr_valid && $stable(chr_data) && $stable(chr_fr));

  // R4 and R7: every close names exactly one cause
  a_r4_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    close_pulse |-> $countones({close_fr, close_br}) == 1);

  // R4: a framing close is matched by a count step unless saturated
  a_r4_fr_counted: assert property (@(posedge clk) disable iff (!rst_n)
    close_fr |-> (fr_count != $past(fr_count)) || (&fr_count));

  // R5: hunt only accompanies a framing close
  a_r5_hunt_on_fr: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_pulse |-> close_pulse && close_fr);

  // R6: a break start steps the break count unless saturated
  a_r6_brk_counted: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> (brk_count != $past(brk_count)) || (&brk_count));

  // R6: a break is not also a framing error
  a_r6_no_fr_on_brk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> !close_fr);

  // R8: end of a break never coincides with a start
  a_r8_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |-> !brk_start);
endmodule

bind uart_rx_guard uart_rx_guard_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/uart_rx_guard_tb.sv
module uart_rx_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int CNT_W = 3;
  localparam int LEN_W = 4;
  localparam int CMAX  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic rx_bit = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_parity = 2'd0;
  logic cfg_sync = 1'b0, cfg_rzs = 1'b0, cfg_multidrop = 1'b0;
  logic chr_ready = 1'b1;
  logic chr_valid;
  logic [7:0] chr_data;
  logic chr_fr, chr_perr;
  logic close_pulse, close_fr, close_br, hunt_pulse, brk_start, brk_end;
  logic [LEN_W-1:0] brk_len;
  logic [CNT_W-1:0] fr_count, brk_count;

  int n_chk = 0, n_fail = 0;
  int n_chr = 0, n_cfr = 0, n_cbr = 0, n_hunt = 0, n_bs = 0, n_be = 0;
  logic [7:0] l_data;
  logic l_fr, l_perr;
  int exp_fr = 0, exp_brk = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_guard #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_sync(cfg_sync),
    .cfg_rzs(cfg_rzs), .cfg_multidrop(cfg_multidrop),
    .chr_valid(chr_valid), .chr_ready(chr_ready), .chr_data(chr_data),
    .chr_fr(chr_fr), .chr_perr(chr_perr), .close_pulse(close_pulse),
    .close_fr(close_fr), .close_br(close_br), .hunt_pulse(hunt_pulse),
    .brk_start(brk_start), .brk_end(brk_end), .brk_len(brk_len),
    .fr_count(fr_count), .brk_count(brk_count)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (chr_valid && chr_ready) begin
        n_chr++; l_data = chr_data; l_fr = chr_fr; l_perr = chr_perr;
      end
      if (close_pulse && close_fr) n_cfr++;
      if (close_pulse && close_br) n_cbr++;
      if (hunt_pulse) n_hunt++;
      if (brk_start)  n_bs++;
      if (brk_end)    n_be++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (DIV-2) @(negedge clk);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  // data bits, optional parity, stop; no start bit
  task automatic send_body(input logic [7:0] d, input bit bad_par, input logic stop);
    int nb;
    logic p;
    nb = 5 + int'(cfg_len);
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      send_bit(d[i]);
      p = p ^ d[i];
    end
    if (cfg_parity == 2'd1) send_bit(p ^ bad_par);
    else if (cfg_parity == 2'd2) send_bit(~p ^ bad_par);
    send_bit(stop);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic stop);
    send_bit(1'b0);
    send_body(d, bad_par, stop);
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic t_reset;
    eq("R1 chr_valid", int'(chr_valid), 0);
    eq("R1 pulses", int'({close_pulse, hunt_pulse, brk_start, brk_end}), 0);
    eq("R1 counters", int'(fr_count) + int'(brk_count) + int'(brk_len), 0);
  endtask

  task automatic t_lengths;
    for (int l = 0; l < 4; l++) begin
      int c0;
      logic [7:0] m;
      cfg_len = 2'(l);
      m = 8'((1 << (5 + l)) - 1);
      c0 = n_chr;
      send_frame(8'hB6, 0, 1'b1);
      send_bit(1'b1);
      eq("R2 char count", n_chr - c0, 1);
      eq("R2 data", int'(l_data), int'(8'hB6 & m));
      eq("R2 fr", int'(l_fr), 0);
    end
    cfg_len = 2'd3;
  endtask

  task automatic t_parity;
    cfg_parity = 2'd1;
    send_frame(8'h35, 0, 1'b1); eq("R3 even ok", int'(l_perr), 0);
    send_frame(8'h35, 1, 1'b1); eq("R3 even bad", int'(l_perr), 1);
    cfg_parity = 2'd2;
    send_frame(8'h35, 0, 1'b1); eq("R3 odd ok", int'(l_perr), 0);
    send_frame(8'h35, 1, 1'b1); eq("R3 odd bad", int'(l_perr), 1);
    eq("R3 data", int'(l_data), 8'h35);
    cfg_parity = 2'd0;
  endtask

  task automatic t_framing;
    int c0, f0, h0;
    c0 = n_chr; f0 = n_cfr; h0 = n_hunt;
    cfg_parity = 2'd1;
    send_frame(8'h5A, 1, 1'b0);
    send_bit(1'b1);
    exp_fr = sat(exp_fr + 1);
    eq("R4 delivered", n_chr - c0, 1);
    eq("R4 data", int'(l_data), 8'h5A);
    eq("R4 chr_fr", int'(l_fr), 1);
    eq("R4 parity skipped", int'(l_perr), 0);
    eq("R4 close_fr", n_cfr - f0, 1);
    eq("R4 fr_count", int'(fr_count), exp_fr);
    eq("R5 no hunt", n_hunt - h0, 0);
    cfg_parity = 2'd0;
  endtask

  task automatic t_hunt;
    int h0;
    h0 = n_hunt;
    cfg_multidrop = 1'b1;
    send_frame(8'h21, 0, 1'b0);
    send_bit(1'b1);
    exp_fr = sat(exp_fr + 1);
    eq("R5 hunt", n_hunt - h0, 1);
    cfg_multidrop = 1'b0;
  endtask

  task automatic t_break;
    int c0, b0, f0, s0, e0;
    send_frame(8'h11, 0, 1'b1);
    c0 = n_chr; b0 = n_cbr; f0 = n_cfr; s0 = n_bs; e0 = n_be;
    send_frame(8'h00, 0, 1'b0);
    exp_brk = sat(exp_brk + 1);
    eq("R6 brk_start", n_bs - s0, 1);
    eq("R6 brk_count", int'(brk_count), exp_brk);
    eq("R6 no char", n_chr - c0, 0);
    eq("R6 no fr", n_cfr - f0, 0);
    eq("R7 close_br", n_cbr - b0, 1);
    send_zeros(25);
    send_bit(1'b1);
    eq("R8 brk_end", n_be - e0, 1);
    eq("R8 brk_len", int'(brk_len), 3);
    // second break with nothing pending: no close
    b0 = n_cbr;
    send_frame(8'h00, 0, 1'b0);
    send_bit(1'b1);
    exp_brk = sat(exp_brk + 1);
    eq("R7 no close idle", n_cbr - b0, 0);
    eq("R8 short len", int'(brk_len), 1);
  endtask

  task automatic t_rzs;
    int c0;
    cfg_sync = 1'b1; cfg_rzs = 1'b1;
    c0 = n_chr;
    send_frame(8'h55, 0, 1'b0);
    exp_fr = sat(exp_fr + 1);
    eq("R9 fr char", int'(l_fr), 1);
    send_body(8'h33, 0, 1'b1);
    send_bit(1'b1);
    eq("R9 two chars", n_chr - c0, 2);
    eq("R9 resync data", int'(l_data), 8'h33);
    eq("R9 resync fr", int'(l_fr), 0);
  endtask

  task automatic t_rzs_break;
    int s0, f0, b0;
    s0 = n_bs; f0 = n_cfr;
    send_frame(8'h44, 0, 1'b1);
    b0 = n_cbr;
    send_frame(8'h00, 0, 1'b0);
    exp_fr = sat(exp_fr + 1);
    eq("R10 first is fr", n_cfr - f0, 1);
    eq("R10 no break yet", n_bs - s0, 0);
    send_body(8'h00, 0, 1'b0);
    exp_brk = sat(exp_brk + 1);
    eq("R10 break", n_bs - s0, 1);
    eq("R7 fr already closed", n_cbr - b0, 0);
    send_bit(1'b1);
    eq("R10 len", int'(brk_len), 2);
    eq("R4 fr_count rzs", int'(fr_count), exp_fr);
    cfg_sync = 1'b0; cfg_rzs = 1'b0;
  endtask

  task automatic t_rzs_nosync;
    int c0, s0;
    cfg_sync = 1'b0; cfg_rzs = 1'b1;
    c0 = n_chr;
    send_frame(8'h55, 0, 1'b0);
    send_bit(1'b1);
    send_frame(8'h33, 0, 1'b1);
    exp_fr = sat(exp_fr + 1);
    eq("R11 chars", n_chr - c0, 2);
    eq("R11 data", int'(l_data), 8'h33);
    s0 = n_bs;
    send_frame(8'h00, 0, 1'b0);
    send_bit(1'b1);
    exp_brk = sat(exp_brk + 1);
    eq("R11 single break", n_bs - s0, 1);
    cfg_rzs = 1'b0;
  endtask

  task automatic t_backpressure;
    int c0;
    c0 = n_chr;
    chr_ready = 1'b0;
    send_frame(8'hA1, 0, 1'b1);
    send_frame(8'hB2, 0, 1'b1);
    eq("R2 held valid", int'(chr_valid), 1);
    eq("R2 held data", int'(chr_data), 8'hA1);
    @(negedge clk);
    chr_ready = 1'b1;
    repeat (4) @(negedge clk);
    eq("R2 one taken", n_chr - c0, 1);
    eq("R2 first kept", int'(l_data), 8'hA1);
    eq("R2 drained", int'(chr_valid), 0);
  endtask

  task automatic t_len_sat;
    send_frame(8'h00, 0, 1'b0);
    exp_brk = sat(exp_brk + 1);
    send_zeros(200);
    send_bit(1'b1);
    eq("R8 len saturates", int'(brk_len), 15);
  endtask

  task automatic t_cnt_sat;
    for (int i = 0; i < 8; i++) begin
      send_frame(8'h00, 0, 1'b0);
      send_bit(1'b1);
      send_frame(8'h66, 0, 1'b0);
      send_bit(1'b1);
      exp_brk = sat(exp_brk + 1);
      exp_fr = sat(exp_fr + 1);
    end
    eq("R12 brk_count sat", int'(brk_count), CMAX);
    eq("R12 fr_count sat", int'(fr_count), CMAX);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) send_bit(1'b1);
    t_lengths();
    t_parity();
    t_framing();
    t_hunt();
    t_break();
    t_rzs();
    t_rzs_break();
    t_rzs_nosync();
    t_backpressure();
    t_len_sat();
    t_cnt_sat();
    finish_run();
  end
endmodule